// File: doc/BRIEF.md
# Three-Phase Non-Overlapping Clock Divider with Sleep Gate

This block takes one fast master clock and produces three phase outputs that each repeat once every five master cycles, so each runs at one fifth of the input frequency. A five-position one-hot ring advances on every rising edge. Phase one is taken straight from a rising-edge register. Phases two and three come from registers on the falling edge. Each period of five master cycles therefore holds ten half-cycle slots. Phase one covers slots 1–2, phase two slots 4–5 and phase three slots 8–9. All three phases are one master cycle wide, and the gaps between them are one, two and one slots long. No two phases are ever high together.

Three asynchronous control inputs select a low-power hold. Each passes through a two-flop synchroniser. A fixed Boolean condition is then evaluated on the synchronised values and registered. While the registered condition is true, the ring is emptied, every phase is driven low and the acknowledge output is high. When the condition clears, the ring restarts at its first position, so the first phase after waking is a complete phase one.

Top module: `tpclk_gen`

## Requirements
- R1: While `rst_n` is low, `ph1`, `ph2`, `ph3` and `sleep_ack` are all low.
- R2: While awake, `ph1` rises on a rising edge, stays high for exactly one master cycle, and repeats every five master cycles.
- R3: `ph2` goes high on the falling edge one and a half cycles after `ph1` rises, for one master cycle. `ph3` goes high on the falling edge three and a half cycles after `ph1` rises, for one master cycle. The order is always ph1, ph2, ph3.
- R4: At no instant are two of `ph1`, `ph2`, `ph3` high together.
- R5: The sleep condition is F = (ctl_a AND ctl_b) OR (NOT ctl_a AND ctl_b AND NOT ctl_c) OR (NOT ctl_b). F is false only for ctl_a=0, ctl_b=1, ctl_c=1.
- R6: `sleep_ack` is a rising-edge register. After the control inputs are sampled at a rising edge, it equals F of those values from the third rising edge onward. The latency is the same for entry and for exit.
- R7: While asleep, `ph1` is low. `ph2` and `ph3` fall no later than the first falling edge after `sleep_ack` rises. From then on, all phases stay low until `sleep_ack` falls.
- R8: On the rising edge where `sleep_ack` falls, `ph1` rises, and a full period follows.
- R9: On the first rising edge after reset is released, with the control inputs not requesting sleep, `ph1` rises and the sequence begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock; both edges used |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_a | input | 1 | Sleep control input A (asynchronous) |
| ctl_b | input | 1 | Sleep control input B (asynchronous) |
| ctl_c | input | 1 | Sleep control input C (asynchronous) |
| ph1 | output | 1 | Phase one, slots 1–2 |
| ph2 | output | 1 | Phase two, slots 4–5 |
| ph3 | output | 1 | Phase three, slots 8–9 |
| sleep_ack | output | 1 | High while the phase outputs are held in sleep |

## Verification
Sleep entry can land in the same cycle as any phase, including a falling-edge phase that is halfway through. The gate must then cut that phase at its own next edge, with no glitch and no extension. The bench holds random control patterns for random spans, so that entry and exit fall on every ring position. Between those spans it runs directed sweeps of all eight input codes. Every half cycle it compares all four outputs against a slot model. That model is driven only by the three-edge latency and the slot map stated in the requirements.

// File: rtl/tpclk_pkg.sv
package tpclk_pkg;

    localparam int RING_LEN = 5;

    typedef struct packed {
        logic                sleep;
        logic [RING_LEN-1:0] ring;
    } rise_state_t;

    typedef struct packed {
        logic ph2;
        logic ph3;
    } fall_state_t;

    // Sleep condition; false only for a=0, b=1, c=1
    function automatic logic sleep_cond(input logic a, input logic b, input logic c);
        return (a & b) | (~a & b & ~c) | ~b;
    endfunction

endpackage

// File: rtl/tpclk_sync.sv
module tpclk_sync #(
    parameter int          WIDTH     = 3,
    parameter int          DEPTH     = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0][WIDTH-1:0] chain_d;
    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_comb chain_d[i] = din;
            end else begin : g_next
                always_comb chain_d[i] = chain_q[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {DEPTH{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[DEPTH-1];
endmodule

// File: rtl/tpclk_ring.sv
module tpclk_ring
    import tpclk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sleep_req,
    output logic ph1,
    output logic ph2,
    output logic ph3,
    output logic sleep_ack
);
    localparam int PH2_TAP = 1;
    localparam int PH3_TAP = RING_LEN - 2;
    localparam logic [RING_LEN-1:0] START = RING_LEN'(1);

    rise_state_t r_d, r_q;
    fall_state_t f_d, f_q;
    logic        ring_bad;

    always_comb begin
        r_d      = r_q;
        ring_bad = (r_q.ring == '0) || ((r_q.ring & (r_q.ring - 1'b1)) != '0);
        r_d.sleep = sleep_req;
        if (sleep_req)
            r_d.ring = '0;
        else if (ring_bad)
            r_d.ring = START;
        else
            r_d.ring = {r_q.ring[RING_LEN-2:0], r_q.ring[RING_LEN-1]};
        f_d.ph2 = r_q.ring[PH2_TAP];
        f_d.ph3 = r_q.ring[PH3_TAP];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign ph1       = r_q.ring[0];
    assign ph2       = f_q.ph2;
    assign ph3       = f_q.ph3;
    assign sleep_ack = r_q.sleep;

    // R4: non-overlap seen from both edges
    a_r4_no_overlap_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ph1, ph2, ph3}) <= 1);
    a_r4_no_overlap_fall: assert property (@(negedge clk) disable iff (!rst_n)
        $countones({ph1, ph2, ph3}) <= 1);
    // R2: phase one lasts a single master cycle
    a_r2_ph1_width: assert property (@(posedge clk) disable iff (!rst_n)
        ph1 |=> !ph1);
    // R3: phase two follows phase one unless sleep cut in
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ph1) && !sleep_ack) |-> ph2);
    // R7: settled sleep keeps all phases low
    a_r7_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ack && $past(sleep_ack)) |-> ({ph1, ph2, ph3} == 3'b000));
    // R8: waking starts a full phase one
    a_r8_wake_ph1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_ack) |-> ph1);
endmodule

// File: rtl/tpclk_gen.sv
module tpclk_gen
    import tpclk_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_a,
    input  logic ctl_b,
    input  logic ctl_c,
    output logic ph1,
    output logic ph2,
    output logic ph3,
    output logic sleep_ack
);
    // reset value a=0,b=1,c=1 keeps the block awake out of reset
    localparam logic [2:0] SYNC_RST = 3'b011;

    logic [2:0] ctl_s;
    logic       cond;

    tpclk_sync #(.WIDTH(3), .DEPTH(SYNC_DEPTH), .RST_VAL(SYNC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ctl_a, ctl_b, ctl_c}),
        .dout (ctl_s)
    );

    always_comb cond = sleep_cond(ctl_s[2], ctl_s[1], ctl_s[0]);

    tpclk_ring u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(cond),
        .ph1      (ph1),
        .ph2      (ph2),
        .ph3      (ph3),
        .sleep_ack(sleep_ack)
    );

    // R1: reset holds every output low
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> ({ph1, ph2, ph3, sleep_ack} == 4'b0000));
endmodule

// File: tb/tb_tpclk_gen.sv
module tb_tpclk_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a = 1'b0, b = 1'b1, c = 1'b1;
    logic ph1, ph2, ph3, sleep_ack;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    bit pipe0 = 0, pipe1 = 0;
    bit co_exp = 0;
    int cnt = -1;
    int prev_cnt = -1;

    always #4 clk = ~clk;

    tpclk_gen dut (
        .clk(clk), .rst_n(rst_n), .ctl_a(a), .ctl_b(b), .ctl_c(c),
        .ph1(ph1), .ph2(ph2), .ph3(ph3), .sleep_ack(sleep_ack)
    );

    function automatic bit f_exp(bit x, bit y, bit z);
        return !(!x && y && z);
    endfunction

    task automatic chk(input bit got, input bit exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
        end
    endtask

    // rising edge model step: control values present at this edge
    task automatic step_rise();
        bit new_co;
        new_co   = pipe1;
        pipe1    = pipe0;
        pipe0    = f_exp(a, b, c);
        prev_cnt = cnt;
        co_exp   = new_co;
        if (co_exp)         cnt = -1;
        else if (cnt == -1) cnt = 0;
        else                cnt = (cnt + 1) % 5;
    endtask

    task automatic run_cycle();
        @(posedge clk);
        step_rise();
        #1;
        chk(sleep_ack, co_exp, "R6", "sleep_ack");
        chk(ph1, cnt == 0, co_exp ? "R7" : "R2", "ph1 first half");
        chk(ph2, prev_cnt == 1, co_exp ? "R7" : "R3", "ph2 first half");
        chk(ph3, prev_cnt == 3, co_exp ? "R7" : "R3", "ph3 first half");
        chk(($countones({ph1, ph2, ph3}) <= 1), 1'b1, "R4", "overlap first half");
        #1;
        @(negedge clk);
        #1;
        chk(ph1, cnt == 0, "R2", "ph1 second half");
        chk(ph2, cnt == 1, co_exp ? "R7" : "R3", "ph2 second half");
        chk(ph3, cnt == 3, co_exp ? "R7" : "R3", "ph3 second half");
        chk(($countones({ph1, ph2, ph3}) <= 1), 1'b1, "R4", "overlap second half");
    endtask

    task automatic hold(input bit x, input bit y, input bit z, input int n);
        a = x; b = y; c = z;
        for (int i = 0; i < n; i++) run_cycle();
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit seen_wake;
        void'($urandom(32'h5eed1234));
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(ph1, 0, "R1", "ph1 in reset");
        chk(ph2, 0, "R1", "ph2 in reset");
        chk(ph3, 0, "R1", "ph3 in reset");
        chk(sleep_ack, 0, "R1", "sleep_ack in reset");
        @(negedge clk);
        rst_n = 1'b1;
        // R9: first edge after release starts ph1
        @(posedge clk);
        step_rise();
        #1;
        chk(ph1, 1'b1, "R9", "ph1 after reset");
        chk(sleep_ack, 1'b0, "R9", "sleep_ack after reset");
        @(negedge clk);
        for (int i = 0; i < 12; i++) run_cycle();
        // R5: every input code, held long enough to settle
        for (int code = 0; code < 8; code++) begin
            hold(code[2], code[1], code[0], 4);
            chk(sleep_ack, f_exp(code[2], code[1], code[0]), "R5", $sformatf("code %0d", code));
            hold(1'b0, 1'b1, 1'b1, 9);
        end
        // R8: wake on each ring position of entry
        for (int k = 0; k < 5; k++) begin
            hold(1'b0, 1'b1, 1'b1, 7 + k);
            hold(1'b1, 1'b1, 1'b0, 3);
            a = 1'b0; b = 1'b1; c = 1'b1;
            seen_wake = 0;
            for (int j = 0; j < 6; j++) begin
                run_cycle();
                if (!seen_wake && !co_exp && prev_cnt == -1) begin
                    seen_wake = 1;
                    chk(ph1, 1'b1, "R8", "ph1 at wake");
                end
            end
        end
        // random spans, biased toward awake
        for (int i = 0; i < 300; i++) begin
            int len;
            len = 1 + int'($urandom_range(0, 11));
            if ($urandom_range(0, 9) < 6) hold(1'b0, 1'b1, 1'b1, len);
            else hold(1'($urandom), 1'($urandom), 1'($urandom), len);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule